// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block collects up to twenty-nine interrupt sources into a single request line for a processor. Each source owns one bit of a 32-bit cause register. A pulse or a level on a source line sets its bit, and the bit stays set until software clears it. A companion mask register selects which pending causes may reach the processor. Both registers sit on a small register bus with an address, a write strobe, write data and combinational read data. The mask is at word offset 0 and the cause is at word offset 1.

Cause bits 0, 30 and 31 hold no source. They are read-only summaries that are recomputed every cycle from the stored source bits. Software clears a cause bit by writing 0 to that position; positions written as 1 keep their value. A dispatch helper answers a one-cycle request with the index of the lowest-numbered unmasked pending source. When nothing is pending it raises a spurious flag instead and counts the event.

The dispatch helper is a three-state machine. In IDLE it waits for a request. The transition IDLE->GRANT is taken on a request while a source is pending; it captures the lowest index. The transition IDLE->SPUR is taken on a request while nothing is pending; it bumps the error counter. The transitions GRANT->IDLE and SPUR->IDLE are taken unconditionally after one cycle. The self-loop IDLE->IDLE is taken when there is no request.

Top module: `irq_cause_ctrl`

## Requirements
- R1: Source lines 1 to 29 set the matching cause bit on the clock edge where they are high; source lines 0, 30 and 31 have no effect on the cause register.
- R2: A set cause bit stays set until cleared by a write, and a source high in the same cycle as a clearing write to its bit leaves the bit set.
- R3: A write to the cause register (offset 1) clears each source bit written as 0 and leaves each bit written as 1 unchanged.
- R4: Reading the cause register returns in bit 0 the OR of cause bits 29..1, in bit 30 the OR of bits 29..26 and 20..1, and in bit 31 the OR of bits 25..1; writes to these three positions have no effect.
- R5: The mask register sits at offset 0, and only its bits 1 to 29 are writable; its bits 0, 30 and 31 read as 0. Both registers are zero after reset. Offsets 2 and 3 read as 0 and ignore writes.
- R6: irq_o is high one cycle after any bit 1..29 of (cause AND mask) is set, and low one cycle after none is.
- R7: A dispatch request taken in IDLE with a source pending gives, on the next cycle only, grant_vld high with grant_idx equal to the lowest pending bit number in 1..29.
- R8: A dispatch request taken in IDLE with nothing pending gives, on the next cycle only, spur_o high, and err_cnt increments by one, saturating at 255.
- R9: After GRANT or SPUR the machine returns to IDLE, and a request seen in GRANT or SPUR is ignored; grant_vld and spur_o are never high together and are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register word offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| src_i | input | 32 | Source lines; only bits 1..29 are used |
| disp_req | input | 1 | Dispatch request |
| irq_o | output | 1 | Registered interrupt request to the processor |
| grant_vld | output | 1 | One-cycle dispatch grant |
| grant_idx | output | 5 | Lowest pending source number for the grant |
| spur_o | output | 1 | One-cycle spurious dispatch flag |
| err_cnt | output | ERR_W | Saturating spurious-dispatch counter |

## Verification
Source patterns are chosen around the edges of the summary ranges. Bit 21 tells bit 31 apart from bit 30, bit 26 does the reverse, and bit 29 sits at the top of the source range. This exposes any misplaced range boundary. Masks that cover only part of the pending set show whether the grant comes from the masked set or from the raw causes. The non-source lines 0, 30 and 31 are driven with a full mask to show that they neither set bits nor produce a grant. Directed cases cover a set that collides with a clear, held levels, held dispatch requests and counter saturation.

// File: rtl/irq_cc_pkg.sv
package irq_cc_pkg;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = 5;
    localparam int SRC_LO   = 1;
    localparam int SRC_HI   = 29;
    // summary bit positions (software decodes these)
    localparam int SUM_ANY  = 0;
    localparam int SUM_GRPA = 30;
    localparam int SUM_GRPB = 31;
    localparam logic [DATA_W-1:0] SRC_BITS  = 32'h3FFF_FFFE;
    localparam logic [DATA_W-1:0] GRPA_BITS = 32'h3C1F_FFFE; // 29..26, 20..1
    localparam logic [DATA_W-1:0] GRPB_BITS = 32'h03FF_FFFE; // 25..1

    typedef enum logic [1:0] {
        DS_IDLE  = 2'd0,
        DS_GRANT = 2'd1,
        DS_SPUR  = 2'd2
    } disp_state_e;
endpackage

// File: rtl/irq_cc_regs.sv
module irq_cc_regs
    import irq_cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_i,
    input  logic              mask_we,
    input  logic              cause_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] cause_q
);
    logic [DATA_W-1:0] src_m;
    logic [DATA_W-1:0] cause_kept;
    logic [DATA_W-1:0] cause_nxt;

    always_comb begin
        src_m      = src_i & SRC_BITS;
        cause_kept = cause_we ? (cause_q & wdata) : cause_q;
        // set beats clear
        cause_nxt  = (cause_kept | src_m) & SRC_BITS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            cause_q <= '0;
        end else begin
            if (mask_we) begin
                mask_q <= wdata & SRC_BITS;
            end
            cause_q <= cause_nxt;
        end
    end

    // R2
    src_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_m) |=> ((cause_q & $past(src_m)) == $past(src_m)));

    // R3
    no_silent_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_we |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

    // R5
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(wdata & SRC_BITS)));
endmodule

// File: rtl/irq_cc_prio.sv
module irq_cc_prio
    import irq_cc_pkg::*;
(
    input  logic [DATA_W-1:0] pend,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);
    logic [SRC_HI:SRC_LO-1] seen;
    logic [SRC_HI:SRC_LO]   first;
    logic [IDX_W-1:0]       idx_term [SRC_HI:SRC_LO];
    logic [IDX_W-1:0]       idx_acc  [SRC_HI:SRC_LO-1];

    assign seen[SRC_LO-1]    = 1'b0;
    assign idx_acc[SRC_LO-1] = '0;

    genvar gi;
    generate
        for (gi = SRC_LO; gi <= SRC_HI; gi++) begin : g_bit
            assign first[gi]    = pend[gi] & ~seen[gi-1];
            assign seen[gi]     = seen[gi-1] | pend[gi];
            assign idx_term[gi] = first[gi] ? IDX_W'(gi) : '0;
            assign idx_acc[gi]  = idx_acc[gi-1] | idx_term[gi];
        end
    endgenerate

    assign any = seen[SRC_HI];
    assign idx = idx_acc[SRC_HI];

    // R7
    first_onehot_chk: assert final ($onehot0(first));
endmodule

// File: rtl/irq_cc_dispatch.sv
module irq_cc_dispatch
    import irq_cc_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             any,
    input  logic [IDX_W-1:0] idx_in,
    output logic             grant_vld,
    output logic [IDX_W-1:0] grant_idx,
    output logic             spur,
    output logic [ERR_W-1:0] err_cnt
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    disp_state_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            DS_IDLE:  if (req) state_n = any ? DS_GRANT : DS_SPUR;
            DS_GRANT: state_n = DS_IDLE;
            DS_SPUR:  state_n = DS_IDLE;
            default:  state_n = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DS_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_idx <= '0;
            err_cnt   <= '0;
        end else begin
            if (state_q == DS_IDLE && state_n == DS_GRANT) begin
                grant_idx <= idx_in;
            end
            if (state_q == DS_IDLE && state_n == DS_SPUR && err_cnt != ERR_MAX) begin
                err_cnt <= err_cnt + 1'b1;
            end
        end
    end

    assign grant_vld = (state_q == DS_GRANT);
    assign spur      = (state_q == DS_SPUR);

    // R7
    grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |=> !grant_vld);

    // R7
    grant_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> (grant_idx >= IDX_W'(SRC_LO) && grant_idx <= IDX_W'(SRC_HI)));

    // R8
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spur) |-> ((err_cnt == $past(err_cnt) + 1'b1) ||
                         (($past(err_cnt) == ERR_MAX) && (err_cnt == ERR_MAX))));

    // R9
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_vld, spur}));
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
    import irq_cc_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int MASK_OFS  = 0,
    parameter int CAUSE_OFS = 1,
    parameter int ERR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       src_i,
    input  logic              disp_req,
    output logic              irq_o,
    output logic              grant_vld,
    output logic [4:0]        grant_idx,
    output logic              spur_o,
    output logic [ERR_W-1:0]  err_cnt
);
    localparam logic [ADDR_W-1:0] MASK_A  = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] CAUSE_A = ADDR_W'(CAUSE_OFS);

    logic              mask_we, cause_we;
    logic [DATA_W-1:0] mask_q, cause_q, pend, cause_view;
    logic              pend_any;
    logic [IDX_W-1:0]  pend_idx;

    assign mask_we  = bus_we && (bus_addr == MASK_A);
    assign cause_we = bus_we && (bus_addr == CAUSE_A);

    irq_cc_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .mask_we  (mask_we),
        .cause_we (cause_we),
        .wdata    (bus_wdata),
        .mask_q   (mask_q),
        .cause_q  (cause_q)
    );

    assign pend = cause_q & mask_q;

    irq_cc_prio u_prio (
        .pend (pend),
        .any  (pend_any),
        .idx  (pend_idx)
    );

    irq_cc_dispatch #(.ERR_W(ERR_W)) u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (disp_req),
        .any       (pend_any),
        .idx_in    (pend_idx),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx),
        .spur      (spur_o),
        .err_cnt   (err_cnt)
    );

    always_comb begin
        cause_view           = cause_q & SRC_BITS;
        cause_view[SUM_ANY]  = |(cause_q & SRC_BITS);
        cause_view[SUM_GRPA] = |(cause_q & GRPA_BITS);
        cause_view[SUM_GRPB] = |(cause_q & GRPB_BITS);
    end

    always_comb begin
        if (bus_addr == MASK_A)       bus_rdata = mask_q;
        else if (bus_addr == CAUSE_A) bus_rdata = cause_view;
        else                          bus_rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(pend & SRC_BITS);
    end

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |=> irq_o);

    // R6
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend) |=> !irq_o);

    // R4
    summary_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == CAUSE_A && (bus_rdata[SUM_GRPA] || bus_rdata[SUM_GRPB])) |-> bus_rdata[SUM_ANY]);
endmodule

// File: tb/irq_cause_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_cause_ctrl_tb_top;
    localparam logic [31:0] SRC = 32'h3FFF_FFFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_i = '0;
    logic        disp_req = 1'b0;
    logic        irq_o, grant_vld, spur_o;
    logic [4:0]  grant_idx;
    logic [7:0]  err_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int exp_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_cause_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i),
        .disp_req(disp_req), .irq_o(irq_o), .grant_vld(grant_vld),
        .grant_idx(grant_idx), .spur_o(spur_o), .err_cnt(err_cnt)
    );

    // stimulus vectors: {source pattern, mask}
    localparam logic [63:0] VEC [0:7] = '{
        {32'h0000_0002, 32'hFFFF_FFFF},
        {32'h2000_0000, 32'hFFFF_FFFF},
        {32'h0020_0000, 32'hFFFF_FFFF},
        {32'h0400_0000, 32'hFFFF_FFFF},
        {32'h0000_0F00, 32'h0000_0C00},
        {32'h1000_0004, 32'h1000_0000},
        {32'hC000_0001, 32'hFFFF_FFFF},
        {32'h0000_0010, 32'h0000_0000}
    };

    function automatic logic [31:0] model_view(input logic [31:0] c);
        logic [31:0] v;
        v     = c & SRC;
        v[0]  = |c[29:1];
        v[30] = (|c[29:26]) | (|c[20:1]);
        v[31] = |c[25:1];
        return v;
    endfunction

    function automatic int model_low(input logic [31:0] p);
        for (int i = 1; i <= 29; i++) if (p[i]) return i;
        return 0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic bump_err();
        if (exp_err < 255) exp_err++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state R5 R9
        rd(2'd0, "R5 mask reset", 32'h0);
        rd(2'd1, "R5 cause reset", 32'h0);
        chk("R6 irq reset", {31'b0, irq_o}, 32'h0);
        chk("R9 outputs reset", {30'b0, grant_vld, spur_o}, 32'h0);
        chk("R8 err reset", {24'b0, err_cnt}, 32'h0);

        // table walk R1 R4 R6 R7 R8
        for (int k = 0; k < 8; k++) begin
            logic [31:0] s, m, p;
            s = VEC[k][63:32];
            m = VEC[k][31:0];
            p = s & m & SRC;
            wr(2'd0, m);
            wr(2'd1, 32'h0);
            @(negedge clk); src_i = s;
            @(negedge clk); src_i = '0;
            rd(2'd1, "R1 R4 cause view", model_view(s));
            rd(2'd0, "R5 mask view", m & SRC);
            @(negedge clk);
            chk("R6 irq level", {31'b0, irq_o}, {31'b0, |p});
            @(negedge clk); disp_req = 1'b1;
            @(negedge clk); disp_req = 1'b0;
            if (|p) begin
                chk("R7 grant", {26'b0, grant_vld, grant_idx}, {26'b0, 1'b1, 5'(model_low(p))});
                chk("R7 no spur", {31'b0, spur_o}, 32'h0);
            end else begin
                bump_err();
                chk("R8 spur", {31'b0, spur_o}, 32'h1);
                chk("R8 count", {24'b0, err_cnt}, 32'(exp_err));
            end
            @(negedge clk);
            chk("R9 back to idle", {30'b0, grant_vld, spur_o}, 32'h0);
        end

        // R3: write-0 clears, write-1 keeps
        wr(2'd1, 32'h0);
        @(negedge clk); src_i = 32'h0000_0028;
        @(negedge clk); src_i = '0;
        wr(2'd1, ~32'h0000_0008);
        rd(2'd1, "R3 partial clear", model_view(32'h0000_0020));

        // R4: summary positions ignore writes
        wr(2'd1, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, "R4 summary write ignored", 32'h0);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, "R5 unused offset", 32'h0);
        rd(2'd0, "R5 unused offset write ignored", 32'h0);

        // R2: set wins over same-cycle clear
        @(negedge clk);
        src_i = 32'h0000_0080; bus_addr = 2'd1; bus_wdata = 32'h0; bus_we = 1'b1;
        @(negedge clk);
        src_i = '0; bus_we = 1'b0;
        rd(2'd1, "R2 set beats clear", model_view(32'h0000_0080));
        // R2: held level survives clearing writes
        wr(2'd1, 32'h0);
        src_i = 32'h0000_0200;
        wr(2'd1, 32'h0);
        wr(2'd1, 32'h0);
        rd(2'd1, "R2 held level", model_view(32'h0000_0200));
        src_i = '0;
        wr(2'd1, 32'h0);
        rd(2'd1, "R2 released level clears", 32'h0);

        // R6: irq falls after masking
        wr(2'd0, 32'hFFFF_FFFF);
        @(negedge clk); src_i = 32'h0000_0004;
        @(negedge clk); src_i = '0;
        @(negedge clk);
        chk("R6 irq high", {31'b0, irq_o}, 32'h1);
        wr(2'd0, 32'h0);
        @(negedge clk);
        chk("R6 irq low after mask", {31'b0, irq_o}, 32'h0);
        wr(2'd1, 32'h0);

        // R9: request held two cycles gives one spurious event
        @(negedge clk); disp_req = 1'b1;
        @(negedge clk);
        bump_err();
        chk("R9 spur first", {31'b0, spur_o}, 32'h1);
        @(negedge clk); disp_req = 1'b0;
        chk("R9 held request ignored", {31'b0, spur_o}, 32'h0);
        chk("R9 count once", {24'b0, err_cnt}, 32'(exp_err));

        // R8: saturation
        for (int j = 0; j < 260; j++) begin
            @(negedge clk); disp_req = 1'b1;
            @(negedge clk); disp_req = 1'b0;
            bump_err();
        end
        @(negedge clk);
        chk("R8 saturation", {24'b0, err_cnt}, 32'd255);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule